// File: doc/BRIEF.md
# External Bus Region Chip-Select Sequencer

This block turns single-word requests from a CPU-side port into cycles on an external memory bus. The top two address bits pick one of four regions. Each region has its own active-low select line and its own settings: 8-bit or 16-bit data path, strobe timing paced by the fast block clock or only by a slower system-clock enable, separate read and write wait counts, and (for regions 2 and 3 only) stretching of the strobe by an external ready input.

A static strap chooses the pin arrangement. With separate pins, the address comes out on its own bus and the shared lanes carry only data. With multiplexed pins, every bus cycle starts with an address phase. In that phase a latch-enable pulse is high and the low address half is driven on the shared lanes. The data phase then follows on the same lanes. A 16-bit request to an 8-bit region becomes two byte cycles. The requester is acknowledged once, after the second byte cycle has finished.

Top module: `xbus_csel`

## Requirements
- R1: The region is given by `addr[23:22]` and is latched when the request is accepted. While a bus cycle is in progress, exactly the matching bit of `cs_n` is low and it does not change. `cs_n` is all ones when idle and during the acknowledge cycle.
- R2: With `mux_mode`=1, each byte or word cycle begins with one address step. In that step `ale` is 1, `ad_oe` is 1 and `ad_out` carries the low 16 bits of that cycle's address. With `mux_mode`=0, `ale` never rises.
- R3: A 16-bit request (`size16`=1) to a region whose `cfg_wide` bit is 0 runs two byte cycles. The first is at `addr` and writes `wdata[7:0]`. The second is at `addr`+1 and writes `wdata[15:8]`. Both bytes are driven on `ad_out[7:0]`, with `ad_out[15:8]` at zero. A wide region runs one cycle that drives all of `wdata`.
- R4: Read data is taken from `ad_in` at the last step of each strobe. A wide region takes all 16 bits. A narrow region takes `ad_in[7:0]`: the first byte goes to `rdata[7:0]` and the second to `rdata[15:8]`. A narrow byte read returns zero in `rdata[15:8]`.
- R5: Each cycle has one address step, then a strobe (`rd_n` or `wr_n` low) that lasts wait+1 steps. The wait value is a 3-bit field, 0 to 7. Region k uses bits [3k+2:3k] of `cfg_rd_wait` for reads and of `cfg_wr_wait` for writes.
- R6: In a region whose `cfg_sync` bit is 1, the block advances through the address and strobe phases only on cycles where `sys_tick` is 1. In any other region it advances on every clock.
- R7: When the `cfg_hs` bit is 1 for region 2 or 3, the strobe holds after its programmed wait until `ready` is sampled 1. Regions 0 and 1 ignore `ready` whatever their `cfg_hs` bit is.
- R8: `ack` is high for exactly one clock after the final strobe. `rd_n` and `wr_n` are never low together. After reset, all selects and strobes are high and `ack`=0.
- R9: A request is accepted only while the block is idle. Region settings and wait values are captured at acceptance, so later changes do not affect the cycle in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request, held until ack |
| we | input | 1 | 1 = write, 0 = read |
| size16 | input | 1 | 1 = 16-bit access, 0 = byte access |
| addr | input | 24 | Byte address of the access |
| wdata | input | 16 | Write data |
| ack | output | 1 | One-clock completion pulse |
| rdata | output | 16 | Read data, valid with ack |
| cfg_wide | input | 4 | Per-region 16-bit data path |
| cfg_sync | input | 4 | Per-region pacing by sys_tick |
| cfg_hs | input | 4 | Per-region ready handshake (regions 2, 3 only) |
| cfg_rd_wait | input | 12 | Per-region read wait, 3 bits each |
| cfg_wr_wait | input | 12 | Per-region write wait, 3 bits each |
| mux_mode | input | 1 | Strap: 1 = multiplexed address/data |
| sys_tick | input | 1 | System-clock step enable |
| ready | input | 1 | External ready for handshake regions |
| cs_n | output | 4 | Active-low region selects |
| ale | output | 1 | Address latch enable (multiplexed mode) |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| addr_out | output | 24 | Address of the current byte or word cycle |
| ad_out | output | 16 | Shared lanes: address or write data |
| ad_oe | output | 1 | Drive enable for ad_out |
| ad_in | input | 16 | Read data from the shared lanes |

## Verification
The bench concentrates on the narrow-region split. If the byte order were swapped, the bytes would appear at the wrong address and rdata would come back with its halves exchanged. If the early acknowledge were wrong, ack would come after the first byte. It drives ready low on region 0, which has its handshake bit set, and on region 2. If region 0 obeyed ready, its cycle would stretch. If region 2 ignored ready, its strobe would end too early. It also covers wait values of 0 and 7, pacing by sys_tick, and a change to the wait setting in the middle of a cycle. Any of these faults changes the length of the cycle. It then shows up in the clock-by-clock comparison against the behavioural model.

// File: rtl/xbus_pkg.sv
`timescale 1ns/1ps
package xbus_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_STROBE = 2'd2,
        ST_DONE   = 2'd3
    } xb_state_e;
endpackage

// File: rtl/xbus_region_sel.sv
`timescale 1ns/1ps
module xbus_region_sel #(
    parameter int NREG = 4,
    parameter int WW   = 3,
    parameter logic [NREG-1:0] HS_MASK = 'b1100,
    localparam int RW = $clog2(NREG)
) (
    input  logic [RW-1:0]      region,
    input  logic               we,
    input  logic [NREG-1:0]    cfg_wide,
    input  logic [NREG-1:0]    cfg_sync,
    input  logic [NREG-1:0]    cfg_hs,
    input  logic [NREG*WW-1:0] cfg_rd_wait,
    input  logic [NREG*WW-1:0] cfg_wr_wait,
    output logic               wide,
    output logic               sync,
    output logic               hs,
    output logic [WW-1:0]      wt
);
    logic [NREG-1:0] hs_ok;

    // only regions listed in HS_MASK may honour the ready input
    for (genvar i = 0; i < NREG; i++) begin : g_hs
        assign hs_ok[i] = cfg_hs[i] & HS_MASK[i];
    end

    assign wide = cfg_wide[region];
    assign sync = cfg_sync[region];
    assign hs   = hs_ok[region];
    assign wt   = we ? cfg_wr_wait[region*WW +: WW] : cfg_rd_wait[region*WW +: WW];
endmodule

// File: rtl/xbus_lane.sv
`timescale 1ns/1ps
module xbus_lane #(
    parameter int DW = 16,
    localparam int BW = DW / 2
) (
    input  logic          mux_mode,
    input  logic          setup,
    input  logic          busy,
    input  logic          we,
    input  logic          wide,
    input  logic          beat,
    input  logic [DW-1:0] baddr,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] ad_in,
    input  logic [DW-1:0] rdata_q,
    output logic [DW-1:0] ad_out,
    output logic          ad_oe,
    output logic [DW-1:0] rdata_cap
);
    logic [DW-1:0] wlane;

    always_comb begin
        if (wide)      wlane = wdata;
        else if (beat) wlane = {{BW{1'b0}}, wdata[DW-1:BW]};
        else           wlane = {{BW{1'b0}}, wdata[BW-1:0]};

        ad_oe = busy && (we || (mux_mode && setup));

        if (busy && mux_mode && setup) ad_out = baddr;
        else if (busy && we)           ad_out = wlane;
        else                           ad_out = '0;

        rdata_cap = rdata_q;
        if (wide)      rdata_cap = ad_in;
        else if (beat) rdata_cap[DW-1:BW] = ad_in[BW-1:0];
        else           rdata_cap[BW-1:0]  = ad_in[BW-1:0];
    end
endmodule

// File: rtl/xbus_csel.sv
`timescale 1ns/1ps
module xbus_csel #(
    parameter int AW   = 24,
    parameter int DW   = 16,
    parameter int NREG = 4,
    parameter int WW   = 3,
    parameter logic [NREG-1:0] HS_MASK = 'b1100,
    localparam int RW = $clog2(NREG)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req,
    input  logic               we,
    input  logic               size16,
    input  logic [AW-1:0]      addr,
    input  logic [DW-1:0]      wdata,
    output logic               ack,
    output logic [DW-1:0]      rdata,
    input  logic [NREG-1:0]    cfg_wide,
    input  logic [NREG-1:0]    cfg_sync,
    input  logic [NREG-1:0]    cfg_hs,
    input  logic [NREG*WW-1:0] cfg_rd_wait,
    input  logic [NREG*WW-1:0] cfg_wr_wait,
    input  logic               mux_mode,
    input  logic               sys_tick,
    input  logic               ready,
    output logic [NREG-1:0]    cs_n,
    output logic               ale,
    output logic               rd_n,
    output logic               wr_n,
    output logic [AW-1:0]      addr_out,
    output logic [DW-1:0]      ad_out,
    output logic               ad_oe,
    input  logic [DW-1:0]      ad_in
);
    import xbus_pkg::*;

    typedef struct packed {
        xb_state_e     st;
        logic [RW-1:0] region;
        logic          we;
        logic          wide;
        logic          sync;
        logic          hs;
        logic [WW-1:0] wt;
        logic [WW-1:0] cnt;
        logic          beat;
        logic          last;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic [DW-1:0] rdata;
    } ctl_t;

    ctl_t q, d;

    logic [RW-1:0] req_region;
    logic          sel_wide, sel_sync, sel_hs;
    logic [WW-1:0] sel_wt;
    logic          busy, setup, step;
    logic [AW-1:0] beat_addr;
    logic [DW-1:0] rdata_cap;

    assign req_region = addr[AW-1 -: RW];

    xbus_region_sel #(.NREG(NREG), .WW(WW), .HS_MASK(HS_MASK)) u_sel (
        .region      (req_region),
        .we          (we),
        .cfg_wide    (cfg_wide),
        .cfg_sync    (cfg_sync),
        .cfg_hs      (cfg_hs),
        .cfg_rd_wait (cfg_rd_wait),
        .cfg_wr_wait (cfg_wr_wait),
        .wide        (sel_wide),
        .sync        (sel_sync),
        .hs          (sel_hs),
        .wt          (sel_wt)
    );

    assign setup     = (q.st == ST_SETUP);
    assign busy      = setup || (q.st == ST_STROBE);
    assign step      = q.sync ? sys_tick : 1'b1;
    assign beat_addr = q.addr + AW'(q.beat);

    xbus_lane #(.DW(DW)) u_lane (
        .mux_mode  (mux_mode),
        .setup     (setup),
        .busy      (busy),
        .we        (q.we),
        .wide      (q.wide),
        .beat      (q.beat),
        .baddr     (beat_addr[DW-1:0]),
        .wdata     (q.wdata),
        .ad_in     (ad_in),
        .rdata_q   (q.rdata),
        .ad_out    (ad_out),
        .ad_oe     (ad_oe),
        .rdata_cap (rdata_cap)
    );

    always_comb begin
        d = q;
        unique case (q.st)
            ST_IDLE: begin
                if (req) begin
                    d.st     = ST_SETUP;
                    d.region = req_region;
                    d.we     = we;
                    d.wide   = sel_wide;
                    d.sync   = sel_sync;
                    d.hs     = sel_hs;
                    d.wt     = sel_wt;
                    d.cnt    = '0;
                    d.beat   = 1'b0;
                    d.last   = size16 ? sel_wide : 1'b1;
                    d.addr   = addr;
                    d.wdata  = wdata;
                    d.rdata  = '0;
                end
            end
            ST_SETUP: begin
                if (step) begin
                    d.st  = ST_STROBE;
                    d.cnt = q.wt;
                end
            end
            ST_STROBE: begin
                if (step) begin
                    if (q.cnt != '0) begin
                        d.cnt = q.cnt - 1'b1;
                    end else if (!(q.hs && !ready)) begin
                        if (!q.we) d.rdata = rdata_cap;
                        if (q.last) begin
                            d.st = ST_DONE;
                        end else begin
                            d.beat = 1'b1;
                            d.last = 1'b1;
                            d.st   = ST_SETUP;
                        end
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    for (genvar i = 0; i < NREG; i++) begin : g_cs
        assign cs_n[i] = !(busy && (q.region == RW'(i)));
    end

    assign ale      = mux_mode && setup;
    assign rd_n     = !((q.st == ST_STROBE) && !q.we);
    assign wr_n     = !((q.st == ST_STROBE) && q.we);
    assign addr_out = busy ? beat_addr : '0;
    assign ack      = (q.st == ST_DONE);
    assign rdata    = q.rdata;
endmodule

// File: rtl/xbus_csel_chk.sv
`timescale 1ns/1ps
module xbus_csel_chk #(
    parameter int NREG = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            mux_mode,
    input logic [NREG-1:0] cs_n,
    input logic            ale,
    input logic            rd_n,
    input logic            wr_n,
    input logic            ack
);
    // R1
    cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    // R1
    cs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&cs_n) && !(&$past(cs_n))) |-> (cs_n == $past(cs_n)));

    // R1
    ack_cs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> (&cs_n));

    // R8
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    // R8
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    // R2
    ale_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (mux_mode && rd_n && wr_n));

    // R8
    strobe_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n || !wr_n) |-> !(&cs_n));
endmodule

bind xbus_csel xbus_csel_chk #(.NREG(NREG)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mux_mode (mux_mode),
    .cs_n     (cs_n),
    .ale      (ale),
    .rd_n     (rd_n),
    .wr_n     (wr_n),
    .ack      (ack)
);

// File: tb/xbus_csel_test.sv
`timescale 1ns/1ps
module xbus_csel_test;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        req = 1'b0, we = 1'b0, size16 = 1'b0;
    logic [23:0] addr = '0;
    logic [15:0] wdata = '0;
    logic        ack;
    logic [15:0] rdata;
    logic [3:0]  cfg_wide = 4'b1101, cfg_sync = 4'b0000, cfg_hs = 4'b0101;
    logic [11:0] cfg_rd_wait = {3'd7, 3'd0, 3'd1, 3'd2};
    logic [11:0] cfg_wr_wait = {3'd0, 3'd1, 3'd0, 3'd3};
    logic        mux_mode = 1'b0, sys_tick = 1'b1, ready = 1'b1;
    logic [3:0]  cs_n;
    logic        ale, rd_n, wr_n, ad_oe;
    logic [23:0] addr_out;
    logic [15:0] ad_out, ad_in = '0;

    xbus_csel uut (.*);

    int n_chk = 0, n_fail = 0;
    int rdy_hold = 0, tick_ctr = 0, last_cyc = 0;
    bit prev_strobe = 1'b0;
    logic [23:0] q_a[$];
    logic [15:0] q_d[$];
    logic [15:0] q_ale[$];
    logic [3:0]  q_cs[$];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] lo_pat(input logic [23:0] a);
        return a[7:0] ^ 8'hA5;
    endfunction
    function automatic logic [7:0] hi_pat(input logic [23:0] a);
        return a[7:0] ^ 8'h3C;
    endfunction

    // behavioural reference model: phase 0 idle, 1 address, 2 strobe, 3 ack
    int m_st = 0, m_cnt = 0, m_b = 0, m_nb = 1, m_w = 0, m_reg = 0;
    bit m_we = 0, m_sync = 0, m_hs = 0;
    logic [23:0] m_addr = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0;
        end else begin
            bit stp;
            stp = m_sync ? sys_tick : 1'b1;
            case (m_st)
                0: if (req) begin
                    m_reg  = int'(addr[23:22]);
                    m_we   = we;
                    m_addr = addr;
                    m_sync = cfg_sync[m_reg];
                    m_hs   = cfg_hs[m_reg] && (m_reg >= 2);
                    m_w    = we ? int'(cfg_wr_wait[m_reg*3 +: 3]) : int'(cfg_rd_wait[m_reg*3 +: 3]);
                    m_nb   = (size16 && !cfg_wide[m_reg]) ? 2 : 1;
                    m_b    = 0;
                    m_st   = 1;
                end
                1: if (stp) begin m_cnt = m_w; m_st = 2; end
                2: if (stp) begin
                    if (m_cnt > 0) m_cnt--;
                    else if (!(m_hs && !ready)) begin
                        if (m_b + 1 < m_nb) begin m_b++; m_st = 1; end
                        else m_st = 3;
                    end
                end
                default: m_st = 0;
            endcase
        end
    end

    // per-cycle comparison, bus responder and recording, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            logic [3:0]  e_cs;
            logic [23:0] e_addr;
            bit busy, strobe;
            busy   = (m_st == 1) || (m_st == 2);
            e_cs   = busy ? ~(4'b0001 << m_reg) : 4'hF;
            e_addr = busy ? m_addr + 24'(m_b) : 24'h0;
            chk("R1 cs_n per cycle", 32'(cs_n), 32'(e_cs));
            chk("R2 ale per cycle", 32'(ale), 32'(mux_mode && m_st == 1));
            chk("R5 rd_n per cycle", 32'(rd_n), 32'(!(m_st == 2 && !m_we)));
            chk("R5 wr_n per cycle", 32'(wr_n), 32'(!(m_st == 2 && m_we)));
            chk("R8 ack per cycle", 32'(ack), 32'(m_st == 3));
            chk("R3 addr_out per cycle", 32'(addr_out), 32'(e_addr));
            strobe = !rd_n || !wr_n;
            if (strobe && !prev_strobe) begin
                q_a.push_back(addr_out);
                q_d.push_back(ad_out);
                q_cs.push_back(~cs_n);
            end
            if (ale) q_ale.push_back(ad_out);
            prev_strobe = strobe;
            if (strobe && rdy_hold > 0) rdy_hold--;
        end
        ready    = (rdy_hold == 0);
        ad_in    = {hi_pat(addr_out), lo_pat(addr_out)};
        sys_tick = (tick_ctr % 3 == 0);
        tick_ctr++;
    end

    task automatic xfer(input bit w, input logic [23:0] a, input bit s16,
                        input logic [15:0] wd, input int hold, input int exp_cyc);
        int cyc;
        bit got, narrow;
        int nb;
        @(negedge clk);
        narrow = !cfg_wide[a[23:22]];
        nb = (s16 && narrow) ? 2 : 1;
        rdy_hold = hold;
        q_a.delete(); q_d.delete(); q_ale.delete(); q_cs.delete();
        we = w; addr = a; size16 = s16; wdata = wd; req = 1'b1;
        cyc = 0; got = 1'b0;
        while (!got && cyc < 400) begin
            @(negedge clk);
            cyc++;
            if (ack) got = 1'b1;
        end
        req = 1'b0;
        last_cyc = cyc;
        chk("R8 ack received", 32'(got), 32'd1);
        if (exp_cyc > 0) chk("R5 cycles to ack", cyc, exp_cyc);
        chk("R3 byte/word cycle count", q_a.size(), nb);
        chk("R2 ale pulse count", q_ale.size(), mux_mode ? nb : 0);
        for (int i = 0; i < q_a.size() && i < nb; i++) begin
            logic [23:0] ai;
            logic [15:0] ed;
            ai = a + 24'(i);
            chk("R1 selected region", 32'(q_cs[i]), 32'(4'b0001 << a[23:22]));
            chk("R3 cycle address", 32'(q_a[i]), 32'(ai));
            if (w) begin
                ed = narrow ? {8'h00, (i == 1) ? wd[15:8] : wd[7:0]} : wd;
                chk("R3 write lanes", 32'(q_d[i]), 32'(ed));
            end
            if (mux_mode && i < q_ale.size())
                chk("R2 address on shared lanes", 32'(q_ale[i]), 32'(ai[15:0]));
        end
        if (!w) begin
            logic [15:0] er;
            if (!narrow)  er = {hi_pat(a), lo_pat(a)};
            else if (s16) er = {lo_pat(a + 24'd1), lo_pat(a)};
            else          er = {8'h00, lo_pat(a)};
            chk("R4 read data", 32'(rdata), 32'(er));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        chk("R8 reset cs_n", 32'(cs_n), 32'hF);
        chk("R8 reset strobes", 32'({rd_n, wr_n}), 32'h3);
        chk("R8 reset ack", 32'(ack), 32'd0);
        chk("R8 reset ale", 32'(ale), 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R7 region 0 ignores ready despite its handshake bit; R5 wait 2
        xfer(1'b0, 24'h001234, 1'b1, 16'h0, 5, 5);
        xfer(1'b1, 24'h001236, 1'b1, 16'hA55A, 0, 6);
        // R3/R4 narrow region split
        xfer(1'b0, 24'h400010, 1'b1, 16'h0, 0, 7);
        xfer(1'b1, 24'h400020, 1'b1, 16'hBEEF, 0, 5);
        xfer(1'b0, 24'h400031, 1'b0, 16'h0, 0, 4);
        // R5 wait 7 and 0
        xfer(1'b0, 24'hC00FFE, 1'b1, 16'h0, 0, 10);
        xfer(1'b1, 24'hC00FF0, 1'b1, 16'h1234, 0, 3);
        // R7 handshake region 2
        xfer(1'b0, 24'h800100, 1'b1, 16'h0, 4, -1);
        chk("R7 strobe stretched by ready", 32'(last_cyc > 3), 32'd1);
        xfer(1'b0, 24'h800104, 1'b1, 16'h0, 0, 3);
        // R6 synchronous pacing
        cfg_sync[2] = 1'b1;
        xfer(1'b0, 24'h800200, 1'b1, 16'h0, 0, -1);
        chk("R6 paced by sys_tick", 32'(last_cyc > 4), 32'd1);
        cfg_sync[2] = 1'b0;
        // R2 multiplexed lanes
        mux_mode = 1'b1;
        xfer(1'b0, 24'h00ABC0, 1'b1, 16'h0, 0, 5);
        xfer(1'b1, 24'h40CDE2, 1'b1, 16'h6789, 0, 5);
        mux_mode = 1'b0;
        // R9 settings captured at acceptance
        fork
            xfer(1'b0, 24'hC00100, 1'b1, 16'h0, 0, 10);
            begin
                repeat (3) @(negedge clk);
                cfg_rd_wait[11:9] = 3'd0;
            end
        join
        xfer(1'b0, 24'hC00200, 1'b1, 16'h0, 0, 3);

        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule